// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel signed samples. The stream uses a bit clock, a frame clock running at the sample rate, and one or two data lines. Every pin is sampled by the block's system clock, which must run several times faster than the bit clock. Data bits and the frame-clock level are taken on each rising edge of the bit clock. Each frame yields a left and a right word of up to 24 bits, in two's complement, MSB first. Both words appear on the outputs sign-extended to 24 bits, with a one-cycle valid pulse.

Three framings are selected by pins. The meaning of three of the pins changes with the framing. With the format pin low, one line carries the two channels in turn, right-justified to the frame-clock edges, and two pins set the word length. With the format pin high, the first shared pin becomes a second format select. The two other shared pins then carry data: either a single left-justified line with the channels in turn, or one line per channel arriving together. A strobe marks each frame start edge, so a downstream timing controller can align to it.

Top module: `audio_rx_top`

## Requirements
- R1: With `fmt_i` low, data comes in on `pin_a_i` with 24-bit words. The word that ends in the last bit-clock rising edge before a frame-clock edge is captured. The half-frame after the rising frame edge is the left channel.
- R2: With `fmt_i` low, `pin_b_i`/`pin_c_i` set the word length. 0/0 gives 24 bits, 1/0 gives 20, 0/1 gives 18 and 1/1 gives 16. The word is sign-extended to 24 bits from its top bit.
- R3: In the right-justified framing, bits that arrive before the selected word length are don't-care. They do not affect the captured word.
- R4: With `fmt_i` high and `pin_a_i` low, 24-bit left-justified words alternate on `pin_b_i`. The frame start is the falling frame-clock edge, and the half-frame after it carries the left channel.
- R5: In both left-justified framings, only the first 24 bits after the relevant frame edge are kept. Later bits in the same half-frame or frame are ignored.
- R6: With `fmt_i` and `pin_a_i` both high, left-justified 24-bit words arrive together: left on `pin_b_i`, right on `pin_c_i`. The capture starts at the rising frame-clock edge.
- R7: `valid_o` is high for exactly one cycle, once per frame, at the frame start edge that follows a complete frame. `left_o` and `right_o` change only in that cycle. No valid pulse comes at the first start edge after reset.
- R8: `start_o` pulses for one cycle on each frame start edge. The start edge is the rising edge in the right-justified and two-line framings and the falling edge in the alternating left-justified framing.
- R9: While `rst_n` is low, and just after it is released, `left_o`, `right_o`, `valid_o` and `start_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Frame clock at the sample rate |
| fmt_i | input | 1 | Framing select: low = right-justified alternating |
| pin_a_i | input | 1 | Serial data (fmt low) or second framing select (fmt high) |
| pin_b_i | input | 1 | Word-length select 1 (fmt low) or left/alternating data (fmt high) |
| pin_c_i | input | 1 | Word-length select 2 (fmt low) or right data (fmt high) |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle pulse when both samples update |
| start_o | output | 1 | One-cycle pulse on each frame start edge |

## Verification
The hardest case to reach is a polarity switch in the start edge when the framing changes. A frame in the new framing may begin at the same frame-clock level on which the old one ended, so no edge is seen. The stimulus therefore puts a priming frame in the new framing before each data frame, and then a closing frame whose start edge releases the data word. Each half-frame is padded with ones: before the word in the right-justified framing, after the LSB in the left-justified ones. A design that counts the wrong bits therefore shows it in the captured sample. Reset is also applied between frames, to check that the first start edge after it gives no valid pulse.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int unsigned SAMPLE_W = 24;
    localparam int unsigned LEN_W    = $clog2(SAMPLE_W + 1);

    typedef enum logic [1:0] {
        FR_RJ_ALT = 2'd0,
        FR_LJ_ALT = 2'd1,
        FR_LJ_DUO = 2'd2
    } framing_e;

    // selector bits {second, first} -> word length
    function automatic logic [LEN_W-1:0] word_len(input logic sel1, input logic sel2);
        logic [LEN_W-1:0] n;
        case ({sel2, sel1})
            2'b00:   n = LEN_W'(24);
            2'b01:   n = LEN_W'(20);
            2'b10:   n = LEN_W'(18);
            default: n = LEN_W'(16);
        endcase
        return n;
    endfunction

    // keep the low n bits, replicate bit n-1 above them
    function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] raw,
                                                      input logic [LEN_W-1:0]    n);
        logic [SAMPLE_W-1:0] o;
        logic                sgn;
        sgn = raw[n - LEN_W'(1)];
        for (int i = 0; i < SAMPLE_W; i++) begin
            o[i] = (i < int'(n)) ? raw[i] : sgn;
        end
        return o;
    endfunction

endpackage

// File: rtl/rx_pin_sampler.sv
module rx_pin_sampler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_i,
    input  logic       fclk_i,
    input  logic       fmt_i,
    input  logic [2:0] pins_i,
    output logic       bit_stb_o,
    output logic       frm_rise_o,
    output logic       frm_fall_o,
    output logic       fmt_o,
    output logic [2:0] pins_o
);

    typedef struct packed {
        logic       bclk;
        logic       bclk_p;
        logic       frm;
        logic       frm_prev;
        logic       fmt;
        logic [2:0] pins;
    } smp_t;

    smp_t smp_d, smp_q;
    logic stb;

    assign stb = smp_q.bclk & ~smp_q.bclk_p;

    always_comb begin
        smp_d          = smp_q;
        smp_d.bclk     = bclk_i;
        smp_d.bclk_p   = smp_q.bclk;
        smp_d.frm      = fclk_i;
        smp_d.fmt      = fmt_i;
        smp_d.pins     = pins_i;
        if (stb) begin
            smp_d.frm_prev = smp_q.frm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign bit_stb_o  = stb;
    assign frm_rise_o = stb &  smp_q.frm & ~smp_q.frm_prev;
    assign frm_fall_o = stb & ~smp_q.frm &  smp_q.frm_prev;
    assign fmt_o      = smp_q.fmt;
    assign pins_o     = smp_q.pins;

endmodule

// File: rtl/rx_lane_shift.sv
module rx_lane_shift #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_i,
    input  logic         restart_i,
    input  logic         limit_i,
    input  logic         bit_i,
    output logic [W-1:0] sr_o
);

    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] cnt;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (stb_i) begin
            if (restart_i) begin
                ln_d.sr  = {ln_q.sr[W-2:0], bit_i};
                ln_d.cnt = CW'(1);
            end else if (!limit_i || (ln_q.cnt < CNT_MAX)) begin
                ln_d.sr  = {ln_q.sr[W-2:0], bit_i};
                if (ln_q.cnt < CNT_MAX) begin
                    ln_d.cnt = ln_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign sr_o = ln_q.sr;

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.cnt <= CNT_MAX);

    // R5
    lsb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && limit_i && !restart_i && ln_q.cnt == CNT_MAX) |=> $stable(sr_o));

endmodule

// File: rtl/audio_rx_top.sv
module audio_rx_top
    import audio_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fclk_i,
    input  logic                fmt_i,
    input  logic                pin_a_i,
    input  logic                pin_b_i,
    input  logic                pin_c_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                start_o
);

    localparam int unsigned LANES = 2;

    logic       bit_stb, frm_rise, frm_fall, fmt_s;
    logic [2:0] pins_s;

    rx_pin_sampler u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (bclk_i),
        .fclk_i     (fclk_i),
        .fmt_i      (fmt_i),
        .pins_i     ({pin_c_i, pin_b_i, pin_a_i}),
        .bit_stb_o  (bit_stb),
        .frm_rise_o (frm_rise),
        .frm_fall_o (frm_fall),
        .fmt_o      (fmt_s),
        .pins_o     (pins_s)
    );

    framing_e          fr;
    logic              start_ev, mid_ev, restart, limit;
    logic [LEN_W-1:0]  rj_len;
    logic [LANES-1:0]  lane_bit;
    logic [SAMPLE_W-1:0] lane_sr [LANES];

    always_comb begin
        if (!fmt_s)        fr = FR_RJ_ALT;
        else if (pins_s[0]) fr = FR_LJ_DUO;
        else               fr = FR_LJ_ALT;
    end

    assign start_ev = (fr == FR_LJ_ALT) ? frm_fall : frm_rise;
    assign mid_ev   = (fr == FR_LJ_ALT) ? frm_rise : frm_fall;
    assign restart  = (fr == FR_LJ_DUO) ? start_ev : (frm_rise | frm_fall);
    assign limit    = (fr != FR_RJ_ALT);
    assign rj_len   = word_len(pins_s[1], pins_s[2]);
    assign lane_bit[0] = (fr == FR_RJ_ALT) ? pins_s[0] : pins_s[1];
    assign lane_bit[1] = pins_s[2];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rx_lane_shift #(.W(SAMPLE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .stb_i     (bit_stb),
            .restart_i (restart),
            .limit_i   (limit),
            .bit_i     (lane_bit[g]),
            .sr_o      (lane_sr[g])
        );
    end

    typedef struct packed {
        logic                armed;
        logic [SAMPLE_W-1:0] lpend;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
        logic                start;
    } ctl_t;

    ctl_t ct_d, ct_q;
    logic [SAMPLE_W-1:0] word_a;

    assign word_a = (fr == FR_RJ_ALT) ? sign_fill(lane_sr[0], rj_len) : lane_sr[0];

    always_comb begin
        ct_d       = ct_q;
        ct_d.valid = 1'b0;
        ct_d.start = 1'b0;
        if (mid_ev && fr != FR_LJ_DUO) begin
            ct_d.lpend = word_a;
        end
        if (start_ev) begin
            ct_d.start = 1'b1;
            ct_d.armed = 1'b1;
            if (ct_q.armed) begin
                ct_d.valid = 1'b1;
                if (fr == FR_LJ_DUO) begin
                    ct_d.left  = lane_sr[0];
                    ct_d.right = lane_sr[1];
                end else begin
                    ct_d.left  = ct_q.lpend;
                    ct_d.right = word_a;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign left_o  = ct_q.left;
    assign right_o = ct_q.right;
    assign valid_o = ct_q.valid;
    assign start_o = ct_q.start;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    valid_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> start_o);

    // R7
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R8
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: tb/sim_audio_rx_top.sv
`timescale 1ns/1ps
module sim_audio_rx_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fclk = 1'b0, fmt = 1'b0;
    logic        pa = 1'b0, pb = 1'b0, pc = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o, start_o;

    always #4 clk = ~clk;

    audio_rx_top u0 (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .fmt_i(fmt),
        .pin_a_i(pa), .pin_b_i(pb), .pin_c_i(pc),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .start_o(start_o)
    );

    int checks = 0, fails = 0;
    int vcnt = 0, scnt = 0, wide = 0;
    logic [23:0] last_l = '0, last_r = '0;
    logic        start_lvl = 1'b0, prev_v = 1'b0;
    bit          done = 0;

    always @(negedge clk) begin
        if (valid_o) begin
            vcnt++; last_l = left_o; last_r = right_o;
            if (prev_v) wide++;
        end
        if (start_o) begin
            scnt++; start_lvl = fclk;
        end
        prev_v = valid_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic f, input logic a, input logic b, input logic c);
        @(negedge clk);
        bclk = 1'b0; fclk = f; pa = a; pb = b; pc = c;
        repeat (3) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // mode 0: right-justified alternating, 1: left-justified alternating, 2: two-line
    task automatic send_frame(input logic [1:0] mode, input logic w1, input logic w2,
                              input logic [23:0] l, input logic [23:0] r);
        int n;
        n = (w1 ? (w2 ? 16 : 20) : (w2 ? 18 : 24));
        fmt = (mode != 2'd0);
        for (int h = 0; h < 2; h++) begin
            for (int i = 0; i < 32; i++) begin
                logic [23:0] wd;
                logic f, a, b, c;
                int j;
                wd = (h == 0) ? l : r;
                j = h * 32 + i;
                if (mode == 2'd0) begin
                    f = (h == 0);
                    a = (i >= 32 - n) ? wd[n - 1 - (i - (32 - n))] : 1'b1;
                    b = w1; c = w2;
                end else if (mode == 2'd1) begin
                    f = (h == 1);
                    a = 1'b0;
                    b = (i < 24) ? wd[23 - i] : 1'b1;
                    c = 1'b1;
                end else begin
                    f = (h == 0);
                    a = 1'b1;
                    b = (j < 24) ? l[23 - j] : 1'b1;
                    c = (j < 24) ? r[23 - j] : 1'b1;
                end
                send_bit(f, a, b, c);
            end
        end
    endtask

    function automatic logic [23:0] ext(input logic [23:0] v, input int n);
        logic [23:0] o;
        for (int i = 0; i < 24; i++) o[i] = (i < n) ? v[i] : v[n - 1];
        return o;
    endfunction

    // {mode[1:0], w1, w2, left[23:0], right[23:0]}
    localparam int NV = 9;
    localparam logic [51:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 24'h123456, 24'hA5C3F0},
        {2'd0, 1'b1, 1'b0, 24'h081234, 24'h007FFF},
        {2'd0, 1'b0, 1'b1, 24'h020001, 24'h01FFFF},
        {2'd0, 1'b1, 1'b1, 24'h008000, 24'h007FFF},
        {2'd1, 1'b0, 1'b0, 24'h800001, 24'h7FFFFE},
        {2'd1, 1'b0, 1'b0, 24'h0F0F0F, 24'hF0F0F0},
        {2'd2, 1'b0, 1'b0, 24'hDEADBE, 24'h135791},
        {2'd2, 1'b0, 1'b0, 24'h000000, 24'hFFFFFF},
        {2'd0, 1'b1, 1'b1, 24'h001234, 24'h00FFFF}
    };

    initial begin
        #(8ns * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(left_o == 0 && right_o == 0, "R9 left/right in reset", left_o, 24'h0);
        chk(!valid_o && !start_o, "R9 valid/start in reset", {22'h0, valid_o, start_o}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(left_o == 0 && !valid_o, "R9 after release", left_o, 24'h0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  md;
            logic        w1, w2;
            logic [23:0] l, r, el, er;
            int          n;
            string       tag;
            {md, w1, w2, l, r} = VEC[v];
            n = (w1 ? (w2 ? 16 : 20) : (w2 ? 18 : 24));
            if (md == 2'd0) begin
                el = ext(l, n); er = ext(r, n);
                tag = (n == 24) ? "R1 R3 rj24" : "R2 R3 rj-short";
            end else if (md == 2'd1) begin
                el = l; er = r; tag = "R4 R5 lj-alt";
            end else begin
                el = l; er = r; tag = "R6 R5 two-line";
            end
            send_frame(md, w1, w2, 24'h0, 24'h0);
            send_frame(md, w1, w2, l, r);
            vcnt = 0; scnt = 0; wide = 0;
            send_frame(md, w1, w2, 24'h0, 24'h0);
            chk(last_l == el, {tag, " left"}, last_l, el);
            chk(last_r == er, {tag, " right"}, last_r, er);
            chk(vcnt == 1 && wide == 0, "R7 one valid per frame", 24'(vcnt), 24'd1);
            chk(scnt == 1 && start_lvl == (md != 2'd1), "R8 start edge polarity",
                {23'(scnt), start_lvl}, {23'd1, (md != 2'd1)});
        end

        // R9: reset mid-run clears the outputs
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(left_o == 0 && right_o == 0, "R9 mid-run reset", left_o, 24'h0);
        fclk = 1'b0; bclk = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R7: first start edge after reset gives no valid
        vcnt = 0; scnt = 0;
        send_frame(2'd0, 1'b0, 1'b0, 24'h111111, 24'h222222);
        chk(vcnt == 0, "R7 no valid before full frame", 24'(vcnt), 24'd0);
        chk(scnt == 1, "R8 start strobe after reset", 24'(scnt), 24'd1);
        send_frame(2'd0, 1'b0, 1'b0, 24'h0, 24'h0);
        chk(vcnt == 1 && last_l == 24'h111111 && last_r == 24'h222222,
            "R1 R7 first frame after reset", last_r, 24'h222222);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule